// File: doc/BRIEF.md
# Tagged Multichannel Output Register Mux

This block is the digital read-out stage of a six-channel sampling converter. Each channel has a 12-bit result register. The register loads from a parallel sample input when that channel's conversion-done strobe pulses. A host reads results over a 16-bit bus. Every word it reads holds a valid flag, a 3-bit channel tag and the 12-bit result. The bus is driven only while the chip-select and the read strobe are both low. Everything is synchronous to `clk`. The select, strobe, address and byte inputs are assumed to be synchronized already.

A 3-bit mode address decides what a read returns:
- Codes 0 to 5 address one channel directly.
- Code 6 steps through the channels in a fixed rotation.
- Code 7 pops results from a queue in the order they completed.

When `half_width` is high, each word goes out as two 8-bit reads on the low lanes, low byte first.

A two-state machine tracks bus ownership:
- `ST_IDLE` moves to `ST_DRIVE` on the transition OPEN, which happens at a clock edge where both selects are sampled low. OPEN captures the outgoing word.
- `ST_DRIVE` returns to `ST_IDLE` on the transition CLOSE, which happens at the first edge where either select is sampled high. CLOSE pops the queue or advances the rotation once the whole word has been delivered.

Top module: `tagged_result_port`

## Requirements
- R1: `dout_en` goes high one clock edge after `sel_n` and `strobe_n` are both sampled low. It falls at the first edge where either is sampled high. `dout` is 0x0000 whenever `dout_en` is low, including after reset.
- R2: A pulse on `res_done[i]` loads `sample_flat[12*i+11:12*i]` into result register i at that clock edge. It also marks channel i as loaded.
- R3: A full word is {valid in bit 15, tag in bits 14:12, result in bits 11:0}. The tag is the channel index: A0=0, A1=1, B0=2, B1=3, C0=4, C1=5.
- R4: Mode addresses 0 to 5 return that channel's register. The valid bit is 1 only once that channel has been loaded since reset.
- R5: Mode address 6 returns channels in the order 0,1,2,3,4,5,0,... The channel pointer is 0 after reset and advances by one at the CLOSE of each completed word.
- R6: Mode address 7 returns queued results oldest first. Results that complete in the same cycle are queued in ascending channel order. A valid word is popped at the CLOSE of its completed read.
- R7: A mode-7 read of an empty queue returns 0x0000 and pops nothing.
- R8: The queue holds 8 entries. Results arriving while it is full are dropped. When several arrive in one cycle, the lower channels are kept while space remains.
- R9: With `half_width` high, the first read returns word bits 7:0 and the second returns bits 15:8, both on `dout[7:0]` with `dout[15:8]` at zero. The word captured on the first read is held for the second. Queue pops and pointer steps happen only after the second read.
- R10: Whenever `sel_n` is sampled high, the byte phase returns to the low byte.
- R11: `dout` stays constant while `dout_en` stays high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| res_done | input | 6 | Per-channel conversion-done strobes |
| sample_flat | input | 72 | Six 12-bit samples, channel i at bits 12*i+11:12*i |
| sel_n | input | 1 | Active-low chip select |
| strobe_n | input | 1 | Active-low read strobe |
| mode_addr | input | 3 | Channel 0-5, 6 rotation, 7 queue |
| half_width | input | 1 | Byte-split output enable |
| dout | output | 16 | Output word, 0 when not driven |
| dout_en | output | 1 | Bus drive enable (tristate control) |

## Verification
The embedded properties check the following on every cycle:
- bus enable following the selects;
- data stability while driving;
- the rotation pointer range;
- the byte phase clearing on deselect;
- result-register capture;
- queue occupancy bounds, with no pop from an empty queue.

Only the bench scenarios can show the values in the right order. These include the wrap of the rotation, oldest-first queue ordering across mixed arrivals, the drop of overflow entries, the all-zero word once drained, and byte pairs that keep the captured word while new results arrive.

// File: rtl/trp_pkg.sv
package trp_pkg;
    localparam int NCH   = 6;
    localparam int TAG_W = 3;
    localparam logic [TAG_W-1:0] ADDR_CYCLE = 3'b110;
    localparam logic [TAG_W-1:0] ADDR_FIFO  = 3'b111;

    typedef enum logic [0:0] {
        ST_IDLE  = 1'b0,
        ST_DRIVE = 1'b1
    } rd_state_e;
endpackage

// File: rtl/trp_result_bank.sv
module trp_result_bank
    import trp_pkg::*;
#(
    parameter int DATA_W = 12
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic [NCH-1:0]          res_done,
    input  logic [NCH*DATA_W-1:0]   sample_flat,
    output logic [NCH*DATA_W-1:0]   res_q,
    output logic [NCH-1:0]          loaded_q
);
    for (genvar g = 0; g < NCH; g++) begin : g_chan
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                res_q[g*DATA_W +: DATA_W] <= '0;
                loaded_q[g]               <= 1'b0;
            end else if (res_done[g]) begin
                res_q[g*DATA_W +: DATA_W] <= sample_flat[g*DATA_W +: DATA_W];
                loaded_q[g]               <= 1'b1;
            end
        end

        AST_LOAD_CAPTURE: assert property (@(posedge clk) disable iff (!rst_n)
            res_done[g] |=> res_q[g*DATA_W +: DATA_W] == $past(sample_flat[g*DATA_W +: DATA_W])); // R2
        AST_LOAD_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
            res_done[g] |=> loaded_q[g]); // R2
    end
endmodule

// File: rtl/trp_tag_fifo.sv
module trp_tag_fifo
    import trp_pkg::*;
#(
    parameter int DATA_W = 12,
    parameter int DEPTH  = 8
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic [NCH-1:0]            res_done,
    input  logic [NCH*DATA_W-1:0]     sample_flat,
    input  logic                      pop,
    output logic [TAG_W+DATA_W-1:0]   head,
    output logic                      empty
);
    localparam int ENT_W = TAG_W + DATA_W;
    localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CNT_W = $clog2(DEPTH + 1);

    logic [ENT_W-1:0] mem [DEPTH];
    logic [PTR_W-1:0] wr_ptr, rd_ptr;
    logic [CNT_W-1:0] count, free, n_take;
    logic [NCH-1:0]   take;
    logic [PTR_W-1:0] slot [NCH];
    logic             pop_eff;

    assign empty   = (count == '0);
    assign head    = mem[rd_ptr];
    assign pop_eff = pop && !empty;
    assign free    = CNT_W'(DEPTH) - count;

    // Channels are ranked in ascending order; a channel is taken while space remains.
    always_comb begin
        n_take = '0;
        for (int i = 0; i < NCH; i++) begin
            take[i] = res_done[i] && (n_take < free);
            slot[i] = PTR_W'((32'(wr_ptr) + 32'(n_take)) % DEPTH);
            if (take[i]) n_take = n_take + CNT_W'(1);
        end
    end

    always_ff @(posedge clk) begin
        for (int i = 0; i < NCH; i++) begin
            if (take[i]) mem[slot[i]] <= {TAG_W'(i), sample_flat[i*DATA_W +: DATA_W]};
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            count  <= '0;
        end else begin
            wr_ptr <= PTR_W'((32'(wr_ptr) + 32'(n_take)) % DEPTH);
            if (pop_eff) rd_ptr <= PTR_W'((32'(rd_ptr) + 1) % DEPTH);
            count <= count + n_take - CNT_W'(pop_eff);
        end
    end

    AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
        count <= CNT_W'(DEPTH)); // R8
    AST_FULL_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        (count == CNT_W'(DEPTH) && !pop) |=> count == CNT_W'(DEPTH)); // R8
    AST_NO_EMPTY_POP: assert property (@(posedge clk) disable iff (!rst_n)
        pop |-> !empty); // R7
endmodule

// File: rtl/trp_read_fsm.sv
module trp_read_fsm
    import trp_pkg::*;
#(
    parameter int DATA_W = 12
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      sel_n,
    input  logic                      strobe_n,
    input  logic [TAG_W-1:0]          mode_addr,
    input  logic                      half_width,
    input  logic [NCH*DATA_W-1:0]     res_flat,
    input  logic [NCH-1:0]            loaded,
    input  logic [TAG_W+DATA_W-1:0]   fifo_head,
    input  logic                      fifo_empty,
    output logic                      fifo_pop,
    output logic [TAG_W+DATA_W:0]     dout,
    output logic                      dout_en
);
    localparam int WORD_W = 1 + TAG_W + DATA_W;

    rd_state_e           state_q, state_d;
    logic [DATA_W-1:0]   res_arr [NCH];
    logic [TAG_W-1:0]    sel_idx, cyc_ptr, mode_q;
    logic [WORD_W-1:0]   word_new, word_q;
    logic                byte_q, half_q;
    logic                open_req, open_evt, close_evt, finish;

    for (genvar g = 0; g < NCH; g++) begin : g_unpack
        assign res_arr[g] = res_flat[g*DATA_W +: DATA_W];
    end

    assign open_req  = !sel_n && !strobe_n;
    assign open_evt  = (state_q == ST_IDLE) && open_req;
    assign close_evt = (state_q == ST_DRIVE) && !open_req;
    assign finish    = close_evt && (!byte_q || half_q);
    assign fifo_pop  = finish && (mode_q == ADDR_FIFO) && word_q[WORD_W-1];

    // Word formed at OPEN from the current mode address.
    always_comb begin
        sel_idx  = (mode_addr == ADDR_CYCLE) ? cyc_ptr : mode_addr;
        word_new = '0;
        if (mode_addr == ADDR_FIFO) begin
            if (!fifo_empty) word_new = {1'b1, fifo_head};
        end else begin
            word_new = {loaded[sel_idx], sel_idx, res_arr[int'(sel_idx)]};
        end
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:  if (open_req)  state_d = ST_DRIVE;   // OPEN
            ST_DRIVE: if (!open_req) state_d = ST_IDLE;    // CLOSE
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            word_q  <= '0;
            mode_q  <= '0;
            byte_q  <= 1'b0;
            half_q  <= 1'b0;
            cyc_ptr <= '0;
        end else begin
            if (open_evt) begin
                mode_q <= mode_addr;
                byte_q <= half_width;
                if (!(half_width && half_q)) word_q <= word_new;
            end
            if (sel_n)          half_q <= 1'b0;
            else if (close_evt) half_q <= byte_q && !half_q;
            if (finish && mode_q == ADDR_CYCLE)
                cyc_ptr <= (cyc_ptr == TAG_W'(NCH-1)) ? '0 : cyc_ptr + TAG_W'(1);
        end
    end

    assign dout_en = (state_q == ST_DRIVE);

    always_comb begin
        dout = '0;
        if (dout_en) begin
            if (byte_q) dout[7:0] = half_q ? word_q[WORD_W-1 -: 8] : word_q[7:0];
            else        dout      = word_q;
        end
    end

    AST_DRIVE_ON_SELECT: assert property (@(posedge clk) disable iff (!rst_n)
        (!sel_n && !strobe_n) |=> dout_en); // R1
    AST_QUIET_ON_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
        (sel_n || strobe_n) |=> !dout_en); // R1
    AST_STABLE_READ: assert property (@(posedge clk) disable iff (!rst_n)
        (dout_en && $past(dout_en)) |-> $stable(dout)); // R11
    AST_CYC_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        cyc_ptr < TAG_W'(NCH)); // R5
    AST_PHASE_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        sel_n |=> !half_q); // R10
    AST_EMPTY_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (dout_en && mode_q == ADDR_FIFO && !byte_q && !dout[WORD_W-1]) |-> dout == '0); // R7
endmodule

// File: rtl/tagged_result_port.sv
module tagged_result_port
    import trp_pkg::*;
#(
    parameter int DATA_W     = 12,
    parameter int FIFO_DEPTH = 8
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic [NCH-1:0]           res_done,
    input  logic [NCH*DATA_W-1:0]    sample_flat,
    input  logic                     sel_n,
    input  logic                     strobe_n,
    input  logic [TAG_W-1:0]         mode_addr,
    input  logic                     half_width,
    output logic [TAG_W+DATA_W:0]    dout,
    output logic                     dout_en
);
    logic [NCH*DATA_W-1:0]    res_flat;
    logic [NCH-1:0]           loaded;
    logic [TAG_W+DATA_W-1:0]  fifo_head;
    logic                     fifo_empty, fifo_pop;

    trp_result_bank #(.DATA_W(DATA_W)) i_bank (
        .clk(clk), .rst_n(rst_n), .res_done(res_done), .sample_flat(sample_flat),
        .res_q(res_flat), .loaded_q(loaded)
    );

    trp_tag_fifo #(.DATA_W(DATA_W), .DEPTH(FIFO_DEPTH)) i_fifo (
        .clk(clk), .rst_n(rst_n), .res_done(res_done), .sample_flat(sample_flat),
        .pop(fifo_pop), .head(fifo_head), .empty(fifo_empty)
    );

    trp_read_fsm #(.DATA_W(DATA_W)) i_fsm (
        .clk(clk), .rst_n(rst_n), .sel_n(sel_n), .strobe_n(strobe_n),
        .mode_addr(mode_addr), .half_width(half_width), .res_flat(res_flat),
        .loaded(loaded), .fifo_head(fifo_head), .fifo_empty(fifo_empty),
        .fifo_pop(fifo_pop), .dout(dout), .dout_en(dout_en)
    );
endmodule

// File: tb/test_tagged_result_port.sv
module test_tagged_result_port;
    localparam int NCH = 6;
    localparam int DW  = 12;

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic [NCH-1:0]  res_done = '0;
    logic [NCH*DW-1:0] sample_flat = '0;
    logic            sel_n = 1'b1, strobe_n = 1'b1, half_width = 1'b0;
    logic [2:0]      mode_addr = '0;
    logic [15:0]     dout;
    logic            dout_en;

    always #2 clk = ~clk;   // 250 MHz

    tagged_result_port i_tagged_result_port (
        .clk(clk), .rst_n(rst_n), .res_done(res_done), .sample_flat(sample_flat),
        .sel_n(sel_n), .strobe_n(strobe_n), .mode_addr(mode_addr),
        .half_width(half_width), .dout(dout), .dout_en(dout_en)
    );

    typedef struct { logic [15:0] val; string req; } exp_t;
    exp_t exp_q[$];

    int checks = 0, fails = 0;
    bit finished = 0;

    // Reference state built from the requirements
    logic [11:0] ref_data [NCH];
    logic [NCH-1:0] ref_loaded = '0;
    logic [14:0] fq[$];
    int  cyc = 0;
    bit  half = 0;
    logic [15:0] held = '0;

    task automatic chk(input bit ok, input string req, input logic [15:0] act, input logic [15:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    // Monitor: compares the first driven word of each read against the scoreboard.
    bit en_prev = 0;
    always @(negedge clk) begin
        if (rst_n && dout_en && !en_prev) begin
            if (exp_q.size() == 0) begin
                chk(0, "R1 unexpected drive", dout, 16'h0);
            end else begin
                exp_t e;
                e = exp_q.pop_front();
                chk(dout == e.val, e.req, dout, e.val);
            end
        end
        en_prev = dout_en;
    end

    function automatic logic [11:0] sval(input int ch, input int seed);
        return 12'((ch * 679 + seed * 317 + 92) & 12'hFFF);
    endfunction

    task automatic do_load(input logic [NCH-1:0] mask, input int seed);
        @(negedge clk);
        for (int i = 0; i < NCH; i++) begin
            if (mask[i]) begin
                sample_flat[i*DW +: DW] = sval(i, seed);
                ref_data[i] = sval(i, seed);
                ref_loaded[i] = 1'b1;
                if (fq.size() < 8) fq.push_back({3'(i), sval(i, seed)});   // R8 depth 8
            end
        end
        res_done = mask;
        @(negedge clk);
        res_done = '0;
    endtask

    task automatic do_read(input logic [2:0] a, input bit bm, input bit rel_sel, input string req);
        logic [15:0] w, e;
        int ch;
        if (!(bm && half)) begin
            if (a == 3'd7) w = (fq.size() == 0) ? 16'h0000 : {1'b1, fq[0]};
            else begin
                ch = (a == 3'd6) ? cyc : int'(a);
                w = {ref_loaded[ch], 3'(ch), ref_data[ch]};
            end
            held = w;
        end
        e = bm ? {8'h00, half ? held[15:8] : held[7:0]} : held;
        exp_q.push_back('{e, req});
        @(negedge clk);
        mode_addr = a; half_width = bm; sel_n = 1'b0; strobe_n = 1'b0;
        @(negedge clk);          // monitor compares here
        @(negedge clk);
        chk(dout_en && dout == e, {req, " R11 hold"}, dout, e);
        strobe_n = 1'b1;
        if (rel_sel) sel_n = 1'b1;
        @(negedge clk);
        chk(!dout_en && dout == 16'h0, {req, " R1 release"}, dout, 16'h0);
        if (bm && !half) half = 1;
        else begin
            half = 0;
            if (a == 3'd6) cyc = (cyc + 1) % NCH;
            if (a == 3'd7 && held[15]) void'(fq.pop_front());
        end
        if (rel_sel) half = 0;
    endtask

    task automatic probe(input logic s, input logic r);
        @(negedge clk);
        sel_n = s; strobe_n = r;
        @(negedge clk);
        @(negedge clk);
        chk(!dout_en && dout == 16'h0, "R1 single select", dout, 16'h0);
        sel_n = 1'b1; strobe_n = 1'b1;
    endtask

    initial begin
        for (int i = 0; i < NCH; i++) ref_data[i] = '0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk(!dout_en && dout == 16'h0, "R1 reset idle", dout, 16'h0);

        do_read(3'd2, 0, 1, "R4 unloaded channel");
        do_read(3'd7, 0, 1, "R7 empty at start");

        do_load(6'b111111, 1);
        for (int a = 0; a < NCH; a++) do_read(3'(a), 0, 0, "R3 R4 direct read");
        probe(1'b0, 1'b1);
        probe(1'b1, 1'b0);

        for (int k = 0; k < 8; k++) do_read(3'd6, 0, 0, "R5 rotation");
        for (int k = 0; k < 7; k++) do_read(3'd7, 0, 0, "R6 R7 queue drain");

        do_load(6'b101010, 2);
        do_load(6'b000101, 3);
        for (int k = 0; k < 6; k++) do_read(3'd7, 0, 0, "R6 arrival order");

        do_load(6'b111111, 4);
        do_load(6'b111111, 5);
        for (int k = 0; k < 9; k++) do_read(3'd7, 0, 0, "R8 overflow drop");

        // R9 byte pairs
        do_read(3'd3, 1, 0, "R9 low byte");
        do_read(3'd3, 1, 0, "R9 high byte");
        do_read(3'd6, 1, 0, "R9 rotation low");
        do_read(3'd6, 1, 0, "R9 rotation high");
        do_read(3'd6, 1, 1, "R10 low then deselect");
        do_read(3'd6, 1, 0, "R10 low again");
        do_read(3'd6, 1, 0, "R10 high");
        do_read(3'd4, 1, 0, "R9 held low");
        do_load(6'b010000, 6);
        do_read(3'd4, 1, 0, "R9 held high");
        do_read(3'd4, 0, 0, "R2 new value");
        do_read(3'd7, 1, 0, "R9 queue low");
        do_read(3'd7, 1, 0, "R9 queue high");
        do_read(3'd7, 0, 1, "R9 R6 pop after pair");

        repeat (3) @(negedge clk);
        if (exp_q.size() != 0) chk(0, "R1 missing drive", 16'(exp_q.size()), 16'h0);
        finished = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            checks++; fails++;
            $display("FAIL watchdog: actual hung expected done");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end
endmodule